// File: doc/BRIEF.md
# Frame Payload Whitener

This block whitens the 32-bit payload words of a serial storage link. Each data word that sits between a start-of-frame and an end-of-frame word is XORed with 32 keystream bits from a 16-bit linear feedback shift register. Because the operation is a plain XOR with a sequence that restarts at every frame start, the same block descrambles on the receive side. The upstream logic marks control words (primitives), frame start and frame end with flag inputs. Those words pass through unchanged.

A second, independent register produces the keystream for the filler words that follow a continue primitive while repeated primitives are being suppressed. The upstream logic marks such words with the continue-active flag. The filler register ignores frame boundaries and returns to its seed only on a link reset. While filler words flow inside a frame, the payload register holds its value, so the payload sequence picks up where it stopped. Every word is registered once, and the output appears one cycle after it is accepted.

Top module: `frame_whitener`

## Requirements
- R1: The keystream for one word comes from 32 successive register steps. Keystream bit i is state bit 15 before step i, so bit 0 is taken first. Each step shifts the state left by one and inserts at bit 0 the XOR of state bits 15, 14, 12 and 3, which gives the polynomial x^16+x^15+x^13+x^4+1.
- R2: A valid word with `in_sof` set loads the payload register with 0xFFFF, opens a frame and passes through unchanged.
- R3: A valid data word inside an open frame, with all four flags clear, leaves as the input XOR the payload keystream. The payload register then advances by 32 steps.
- R4: A valid word with `in_prim`, `in_sof` or `in_eof` set passes through unchanged. `in_eof` closes the frame. A word with `in_prim` set advances neither register. Priority runs `in_sof`, then `in_eof`, then `in_prim`, then `in_cont`.
- R5: A valid data word outside a frame with `in_cont` clear passes through unchanged.
- R6: A valid filler word (`in_cont` set and no other flag set) is XORed with the filler keystream, and the filler register advances by 32 steps. The payload register holds its value, both inside and outside a frame.
- R7: `link_rst` reseeds the filler register to 0xFFFF. If a filler word arrives in the same cycle, it uses the keystream of the seed. A frame start has no effect on the filler register.
- R8: After 2048 payload words since a frame start, the payload register reloads 0xFFFF. Word 2048 therefore uses the same keystream as word 0. The word counter clears at each frame start.
- R9: `out_valid` equals `in_valid` one cycle later. `out_word` holds its value in cycles where `in_valid` was low.
- R10: During reset, `out_valid` and `out_word` are 0 and both registers hold 0xFFFF.
- R11: A scrambled frame fed back through the block as a new frame returns the original words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_word | input | 32 | Input word |
| in_prim | input | 1 | Word is a primitive |
| in_sof | input | 1 | Word is a frame start |
| in_eof | input | 1 | Word is a frame end |
| in_cont | input | 1 | Word is continue filler |
| link_rst | input | 1 | Link reset event, reseeds the filler register |
| out_valid | output | 1 | Output word present |
| out_word | output | 32 | Processed word |

## Verification
The sequence wrap is the hardest case to reach from the ports. It only occurs after 2048 uninterrupted payload words. The stimulus streams 2050 zero words after one frame start, so the output is the raw keystream, and it compares word 2048 with word 0 and word 2049 with word 1. A second hard case is a link reset in the same cycle as a filler word. It is driven directly, along with filler stretches placed in the middle of a frame, to show that the payload sequence resumes where it stopped.

// File: rtl/frame_whitener_pkg.sv
package frame_whitener_pkg;

   // Action decided for one accepted word
   typedef enum logic [2:0] {
      ACT_IDLE = 3'd0,
      ACT_PASS = 3'd1,
      ACT_SOF  = 3'd2,
      ACT_EOF  = 3'd3,
      ACT_PAY  = 3'd4,
      ACT_FILL = 3'd5
   } fw_act_e;

   localparam int unsigned FW_DEF_LFSR_W = 16;
   localparam logic [FW_DEF_LFSR_W-1:0] FW_DEF_TAPS = 16'hD008;

endpackage

// File: rtl/fw_keystream.sv
// Unrolled LFSR: produces OUT_W keystream bits and the state after OUT_W steps.
module fw_keystream #(
   parameter int unsigned LFSR_W = 16,
   parameter int unsigned OUT_W  = 32,
   parameter logic [LFSR_W-1:0] TAP_MASK = 16'hD008
) (
   input  logic [LFSR_W-1:0] state_i,
   output logic [OUT_W-1:0]  ks_o,
   output logic [LFSR_W-1:0] next_o
);

   if (LFSR_W < 2) begin : g_bad_w
      $error("fw_keystream: LFSR_W must be at least 2");
   end
   if (TAP_MASK[LFSR_W-1] == 1'b0) begin : g_bad_taps
      $error("fw_keystream: top tap must be set");
   end

   logic [LFSR_W-1:0] chain [OUT_W+1];

   assign chain[0] = state_i;

   for (genvar g = 0; g < OUT_W; g++) begin : g_step
      assign ks_o[g]     = chain[g][LFSR_W-1];
      assign chain[g+1]  = {chain[g][LFSR_W-2:0], ^(chain[g] & TAP_MASK)};
   end

   assign next_o = chain[OUT_W];

endmodule

// File: rtl/fw_classify.sv
// Decodes the flag inputs into one action per accepted word.
module fw_classify
   import frame_whitener_pkg::*;
(
   input  logic    in_valid,
   input  logic    in_prim,
   input  logic    in_sof,
   input  logic    in_eof,
   input  logic    in_cont,
   input  logic    in_frame,
   output fw_act_e act_o
);

   always_comb begin
      if (!in_valid)     act_o = ACT_IDLE;
      else if (in_sof)   act_o = ACT_SOF;
      else if (in_eof)   act_o = ACT_EOF;
      else if (in_prim)  act_o = ACT_PASS;
      else if (in_cont)  act_o = ACT_FILL;
      else if (in_frame) act_o = ACT_PAY;
      else               act_o = ACT_PASS;
   end

endmodule

// File: rtl/fw_payload_lane.sv
// Payload keystream register with frame-start reseed and optional sequence wrap.
module fw_payload_lane #(
   parameter int unsigned LFSR_W   = 16,
   parameter int unsigned OUT_W    = 32,
   parameter logic [LFSR_W-1:0] TAP_MASK = 16'hD008,
   parameter logic [LFSR_W-1:0] SEED     = '1,
   parameter int unsigned WRAP_LEN = 2048,
   localparam int unsigned CNT_W   = (WRAP_LEN > 1) ? $clog2(WRAP_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   output logic [OUT_W-1:0]  ks_o,
   output logic [LFSR_W-1:0] state_o,
   output logic [CNT_W-1:0]  wrap_cnt_o
);

   if (WRAP_LEN == 1) begin : g_bad_wrap
      $error("fw_payload_lane: WRAP_LEN must be 0 or at least 2");
   end

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] state_nx;

   fw_keystream #(
      .LFSR_W  (LFSR_W),
      .OUT_W   (OUT_W),
      .TAP_MASK(TAP_MASK)
   ) u_ks (
      .state_i(state_q),
      .ks_o   (ks_o),
      .next_o (state_nx)
   );

   if (WRAP_LEN > 0) begin : g_wrap
      logic [CNT_W-1:0] cnt_q;
      logic             at_end;

      assign at_end = (32'(cnt_q) == WRAP_LEN - 1);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            state_q <= SEED;
            cnt_q   <= '0;
         end else if (load_i) begin
            state_q <= SEED;
            cnt_q   <= '0;
         end else if (adv_i) begin
            if (at_end) begin
               state_q <= SEED;
               cnt_q   <= '0;
            end else begin
               state_q <= state_nx;
               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end

      assign wrap_cnt_o = cnt_q;
   end else begin : g_nowrap
      always_ff @(posedge clk) begin
         if (!rst_n)      state_q <= SEED;
         else if (load_i) state_q <= SEED;
         else if (adv_i)  state_q <= state_nx;
      end

      assign wrap_cnt_o = '0;
   end

   assign state_o = state_q;

endmodule

// File: rtl/fw_fill_lane.sv
// Filler keystream register, reseeded only by a link reset.
module fw_fill_lane #(
   parameter int unsigned LFSR_W   = 16,
   parameter int unsigned OUT_W    = 32,
   parameter logic [LFSR_W-1:0] TAP_MASK = 16'hD008,
   parameter logic [LFSR_W-1:0] SEED     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_rst_i,
   input  logic              adv_i,
   output logic [OUT_W-1:0]  ks_o,
   output logic [LFSR_W-1:0] state_o
);

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] state_eff;
   logic [LFSR_W-1:0] state_nx;

   assign state_eff = link_rst_i ? SEED : state_q;

   fw_keystream #(
      .LFSR_W  (LFSR_W),
      .OUT_W   (OUT_W),
      .TAP_MASK(TAP_MASK)
   ) u_ks (
      .state_i(state_eff),
      .ks_o   (ks_o),
      .next_o (state_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     state_q <= SEED;
      else if (adv_i) state_q <= state_nx;
      else            state_q <= state_eff;
   end

   assign state_o = state_q;

endmodule

// File: rtl/frame_whitener.sv
// Frame payload whitener / de-whitener with continue-filler keystream.
module frame_whitener
   import frame_whitener_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned LFSR_W   = FW_DEF_LFSR_W,
   parameter logic [LFSR_W-1:0] TAP_MASK = FW_DEF_TAPS,
   parameter logic [LFSR_W-1:0] SEED     = '1,
   parameter int unsigned WRAP_LEN = 2048,
   localparam int unsigned CNT_W   = (WRAP_LEN > 1) ? $clog2(WRAP_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_prim,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              in_cont,
   input  logic              link_rst,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);

   if (WORD_W < 1) begin : g_bad_word
      $error("frame_whitener: WORD_W must be positive");
   end

   fw_act_e           act;
   logic              in_frame;
   logic [WORD_W-1:0] pay_ks;
   logic [WORD_W-1:0] fill_ks;
   logic [WORD_W-1:0] mask;
   logic [LFSR_W-1:0] pay_state;
   logic [LFSR_W-1:0] fill_state;
   logic [CNT_W-1:0]  wrap_cnt;

   fw_classify u_cls (
      .in_valid(in_valid),
      .in_prim (in_prim),
      .in_sof  (in_sof),
      .in_eof  (in_eof),
      .in_cont (in_cont),
      .in_frame(in_frame),
      .act_o   (act)
   );

   fw_payload_lane #(
      .LFSR_W  (LFSR_W),
      .OUT_W   (WORD_W),
      .TAP_MASK(TAP_MASK),
      .SEED    (SEED),
      .WRAP_LEN(WRAP_LEN)
   ) u_pay (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (act == ACT_SOF),
      .adv_i     (act == ACT_PAY),
      .ks_o      (pay_ks),
      .state_o   (pay_state),
      .wrap_cnt_o(wrap_cnt)
   );

   fw_fill_lane #(
      .LFSR_W  (LFSR_W),
      .OUT_W   (WORD_W),
      .TAP_MASK(TAP_MASK),
      .SEED    (SEED)
   ) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_rst_i(link_rst),
      .adv_i     (act == ACT_FILL),
      .ks_o      (fill_ks),
      .state_o   (fill_state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)              in_frame <= 1'b0;
      else if (act == ACT_SOF) in_frame <= 1'b1;
      else if (act == ACT_EOF) in_frame <= 1'b0;
   end

   always_comb begin
      unique case (act)
         ACT_PAY:  mask = pay_ks;
         ACT_FILL: mask = fill_ks;
         default:  mask = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_word <= in_word ^ mask;
      end
   end

endmodule

// File: rtl/fw_checker.sv
// Property checker attached to frame_whitener.
module fw_checker #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned LFSR_W   = 16,
   parameter logic [LFSR_W-1:0] SEED = '1,
   parameter int unsigned WRAP_LEN = 2048,
   parameter int unsigned CNT_W    = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] in_word,
   input logic              in_prim,
   input logic              in_sof,
   input logic              in_eof,
   input logic              in_cont,
   input logic              link_rst,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_word,
   input logic              in_frame,
   input logic [LFSR_W-1:0] pay_state,
   input logic [LFSR_W-1:0] fill_state,
   input logic [CNT_W-1:0]  wrap_cnt
);

   logic any_flag;
   logic fill_word;
   logic pay_word;

   assign any_flag  = in_prim || in_sof || in_eof;
   assign fill_word = in_valid && !any_flag && in_cont;
   assign pay_word  = in_valid && !any_flag && !in_cont && in_frame;

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R9
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9
   AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word)); // R9
   AST_PRIM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_flag) |=> (out_word == $past(in_word))); // R4
   AST_PRIM_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_prim && !in_sof && !in_eof && !link_rst) |=>
      ($stable(pay_state) && $stable(fill_state))); // R4
   AST_SOF_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (pay_state == SEED)); // R2
   AST_SOF_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (wrap_cnt == '0)); // R8
   AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_flag && !in_cont && !in_frame) |=>
      (out_word == $past(in_word))); // R5
   AST_FILL_HOLDS_PAY: assert property (@(posedge clk) disable iff (!rst_n)
      fill_word |=> $stable(pay_state)); // R6
   AST_LINK_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      (link_rst && !fill_word) |=> (fill_state == SEED)); // R7
   AST_SOF_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof && !link_rst) |=> $stable(fill_state)); // R7
   AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_word && (32'(wrap_cnt) == WRAP_LEN - 1)) |=> (pay_state == SEED)); // R8

   always_comb begin
      if (rst_n && WRAP_LEN > 0) begin
         AST_WRAP_RANGE: assert (32'(wrap_cnt) < WRAP_LEN); // R8
      end
   end

endmodule

bind frame_whitener fw_checker #(
   .WORD_W  (WORD_W),
   .LFSR_W  (LFSR_W),
   .SEED    (SEED),
   .WRAP_LEN(WRAP_LEN),
   .CNT_W   (CNT_W)
) u_fw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_word   (in_word),
   .in_prim   (in_prim),
   .in_sof    (in_sof),
   .in_eof    (in_eof),
   .in_cont   (in_cont),
   .link_rst  (link_rst),
   .out_valid (out_valid),
   .out_word  (out_word),
   .in_frame  (in_frame),
   .pay_state (pay_state),
   .fill_state(fill_state),
   .wrap_cnt  (wrap_cnt)
);

// File: tb/frame_whitener_bench.sv
`timescale 1ns/1ps
module frame_whitener_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_prim = 1'b0;
   logic        in_sof = 1'b0;
   logic        in_eof = 1'b0;
   logic        in_cont = 1'b0;
   logic        link_rst = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   logic [15:0] m_pay = 16'hFFFF;
   logic [15:0] m_fill = 16'hFFFF;
   int          m_cnt = 0;
   bit          m_frame = 1'b0;
   logic [31:0] m_out = '0;
   logic [31:0] last_out;

   always #10 clk = ~clk;

   frame_whitener u_frame_whitener (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_prim(in_prim), .in_sof(in_sof), .in_eof(in_eof), .in_cont(in_cont),
      .link_rst(link_rst), .out_valid(out_valid), .out_word(out_word)
   );

   // R1: 32 keystream bits, bit i = state[15] before step i
   function automatic logic [31:0] keystream(input logic [15:0] s, output logic [15:0] after);
      logic [31:0] k;
      logic [15:0] r;
      r = s;
      for (int i = 0; i < 32; i++) begin
         k[i] = r[15];
         r = {r[14:0], r[15] ^ r[14] ^ r[12] ^ r[3]};
      end
      after = r;
      return k;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle, update the model, compare at the following negedge.
   task automatic cyc(input string tag, input bit v, input logic [31:0] w,
                      input bit p, input bit s, input bit e, input bit c, input bit lr);
      logic [15:0] nx;
      logic [15:0] feff;
      in_valid = v; in_word = w; in_prim = p; in_sof = s; in_eof = e;
      in_cont = c; link_rst = lr;
      feff = lr ? 16'hFFFF : m_fill;
      m_fill = feff;
      if (v) begin
         if (s) begin
            m_out = w; m_pay = 16'hFFFF; m_cnt = 0; m_frame = 1'b1;
         end else if (e) begin
            m_out = w; m_frame = 1'b0;
         end else if (p) begin
            m_out = w;
         end else if (c) begin
            m_out = w ^ keystream(feff, nx); m_fill = nx;
         end else if (m_frame) begin
            m_out = w ^ keystream(m_pay, nx);
            if (m_cnt == 2047) begin m_pay = 16'hFFFF; m_cnt = 0; end
            else begin m_pay = nx; m_cnt++; end
         end else begin
            m_out = w;
         end
      end
      @(negedge clk);
      check({tag, " valid"}, {31'd0, out_valid}, {31'd0, v});
      check(tag, out_word, m_out);
      last_out = out_word;
   endtask

   task automatic data(input string tag, input logic [31:0] w);
      cyc(tag, 1, w, 0, 0, 0, 0, 0);
   endtask

   logic [31:0] orig [8];
   logic [31:0] scr  [8];
   logic [31:0] k0, k1;

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset valid", {31'd0, out_valid}, 32'd0);
      check("R10 reset word", out_word, 32'd0);
      rst_n = 1'b1;
      cyc("R9 idle", 0, 32'h0, 0, 0, 0, 0, 0);

      data("R5 outside frame", 32'hDEADBEEF);
      cyc("R10 filler from seed", 1, 32'h0, 0, 0, 0, 1, 0);
      cyc("R2 sof pass", 1, 32'h7C95B5B5, 0, 1, 0, 0, 0);
      data("R1 first keystream", 32'h0);
      data("R3 ones", 32'hFFFFFFFF);
      data("R3 pattern", 32'hA5A55A5A);
      cyc("R4 prim mid frame", 1, 32'h7C95AAAA, 1, 0, 0, 0, 0);
      data("R3 after prim", 32'h12345678);
      cyc("R6 filler 1", 1, 32'h0, 0, 0, 0, 1, 0);
      cyc("R6 filler 2", 1, 32'h11111111, 0, 0, 0, 1, 0);
      cyc("R9 gap", 0, 32'hCAFEF00D, 0, 0, 0, 0, 0);
      data("R6 payload resumes", 32'h0);
      cyc("R4 prim with cont", 1, 32'h0BADF00D, 1, 0, 0, 1, 0);
      cyc("R4 eof", 1, 32'h7CB5D5D5, 0, 0, 1, 0, 0);
      data("R5 after eof", 32'h0F0F0F0F);

      cyc("R7 link reset idle", 0, 32'h0, 0, 0, 0, 0, 1);
      cyc("R7 filler after link reset", 1, 32'h0, 0, 0, 0, 1, 0);
      cyc("R7 sof keeps filler", 1, 32'h7C95B5B5, 0, 1, 0, 0, 0);
      cyc("R7 filler continues", 1, 32'h0, 0, 0, 0, 1, 0);
      cyc("R7 link reset with filler", 1, 32'h0, 0, 0, 0, 1, 1);
      cyc("R7 next filler", 1, 32'h0, 0, 0, 0, 1, 0);
      cyc("R4 eof", 1, 32'h7CB5D5D5, 0, 0, 1, 0, 0);

      // R11: scramble then descramble
      cyc("R11 sof a", 1, 32'h7C95B5B5, 0, 1, 0, 0, 0);
      for (int i = 0; i < 8; i++) begin
         orig[i] = 32'h01020304 * (i + 1) ^ {i[7:0], 24'h5A3C00};
         data("R11 scramble", orig[i]);
         scr[i] = last_out;
      end
      cyc("R11 eof a", 1, 32'h7CB5D5D5, 0, 0, 1, 0, 0);
      cyc("R11 sof b", 1, 32'h7C95B5B5, 0, 1, 0, 0, 0);
      for (int i = 0; i < 8; i++) begin
         data("R11 descramble", scr[i]);
         check("R11 recovered", last_out, orig[i]);
      end
      cyc("R11 eof b", 1, 32'h7CB5D5D5, 0, 0, 1, 0, 0);

      // R8: wrap after 2048 words
      cyc("R8 sof", 1, 32'h7C95B5B5, 0, 1, 0, 0, 0);
      k0 = '0; k1 = '0;
      for (int i = 0; i < 2050; i++) begin
         data("R8 stream", 32'h0);
         if (i == 0) k0 = last_out;
         if (i == 1) k1 = last_out;
         if (i == 2048) check("R8 wrap word 2048", last_out, k0);
         if (i == 2049) check("R8 wrap word 2049", last_out, k1);
      end
      cyc("R8 eof", 1, 32'h7CB5D5D5, 0, 0, 1, 0, 0);
      cyc("R9 final idle", 0, 32'h0, 0, 0, 0, 0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule